// File: doc/BRIEF.md
# Command Thread Control Register Bank

This block is the register front end of a small multi-thread command engine. Software reaches it through single-cycle memory-mapped reads and writes. For each thread it keeps these controls: enable, pause request, self-clearing warm reset, an interrupt cause set with its enable mask, the current and end program addresses, and a priority field. It also provides a global time-slice register, an active-low interrupt summary and an "any thread executing" flag.

The execution core never sees the bus. It receives level and pulse strobes from the bank: start, pause request, warm-reset request, and a program-counter load that tells it to drop prefetched words. It answers with pause acknowledge, reset done, busy, program-counter updates, and done, error and fault events. The bank turns those events into sticky interrupt causes. Software clears a cause by writing back the complement of the value it read.

Top module: `cmd_thread_regs`

## Requirements
- R1: After reset every register reads 0, except the summary at 0x010, which reads 0x0000FFFF. `irq`, all thread interrupt lines and all strobes are low.
- R2: Thread t occupies the window at 0x100 + 0x80*t for t in 0..2. The thread registers sit at these window offsets: 0x00 warm reset, 0x04 enable, 0x08 pause, 0x0C status, 0x10 interrupt causes, 0x14 interrupt mask, 0x20 current address, 0x24 end address, 0x40 priority. Any other offset, any unaligned address and any address in a fourth window reads 0, and a write there changes nothing.
- R3: Writing 1 to bit 0 of the warm-reset register raises the thread's reset request. The bit reads 1 until the core pulses reset-done, then reads 0. That completion also clears the enable bit and all interrupt causes.
- R4: Bit 0 of the pause register is the request. The pause request output is high while both the request and enable are 1. Status bit 1 reads 1 only when the request is 1 and either the core has acknowledged since the request was set or the thread is disabled. Writing 0 resumes the thread and clears status bit 1.
- R5: Enable is bit 0 at offset 0x04. Writing 1 while it is 0 raises the start output for exactly one cycle, in the cycle after the write. Writing 1 while it is already 1 raises no start pulse. Status bit 0 mirrors the thread's busy input.
- R6: Interrupt causes: a done event sets bit 0, an error event sets bit 1 and a fault event sets bit 4. No other bit can be set. In a write to the cause register, a 0 bit clears that cause and a 1 bit keeps it. An event that arrives in the same cycle as a clearing write still sets its bit.
- R7: The mask register keeps only bits 0, 1 and 4. A thread's interrupt line is the OR of (causes AND mask). `irq` is the OR of all thread lines.
- R8: Register 0x010 bit t reads 0 exactly when thread t's interrupt line is high. Bits of threads that do not exist read 1, and bits 31:16 read 0.
- R9: Register 0x018 reads 0x80000000 while any busy input is high and 0 otherwise.
- R10: Every bus write to the current address loads the value and pulses the program-counter load output in the next cycle, even when the value is unchanged. A core program-counter update changes the register without a pulse. A bus write wins over a core update in the same cycle.
- R11: The end address keeps all 32 bits. The priority register keeps bits 2:0 only, and the other bits read 0. Both drive their outputs.
- R12: The time-slice register at 0x030 keeps all 32 bits and drives `slotCycles`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Write strobe for one cycle |
| regAddr | input | 12 | Byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from regAddr |
| thrStart | output | 3 | Per-thread start pulse |
| thrSuspReq | output | 3 | Per-thread pause request |
| thrSuspAck | input | 1 per thread (3) | Core reports the thread has stopped |
| thrRstReq | output | 3 | Per-thread warm-reset request |
| thrRstDone | input | 3 | Core reports warm reset complete |
| thrPcLoad | output | 3 | Per-thread refetch pulse |
| thrCurAddr | output | 96 | Current addresses, thread t at [32t+31:32t] |
| thrEndAddr | output | 96 | End addresses |
| thrPrio | output | 9 | Priorities, 3 bits per thread |
| corePcWe | input | 3 | Core program-counter update valid |
| corePc | input | 96 | Core program-counter values |
| coreBusy | input | 3 | Thread executing |
| evtDone | input | 3 | Done event |
| evtErr | input | 3 | Error event |
| evtFault | input | 3 | Fault event |
| thrIrq | output | 3 | Per-thread interrupt line |
| irq | output | 1 | Combined interrupt |
| slotCycles | output | 32 | Time-slice length |

## Verification
Embedded properties check the cycle-level handshakes on every clock. A warm-reset request stays up until reset-done arrives and then clears both itself and enable. A rise of the paused status on an enabled thread must follow an acknowledge. Every current-address write is followed by a refetch pulse. A start pulse only appears with enable set. A cause write leaves no cleared bit behind unless an event re-set it. The effects that only show at the ports are left to the bench scenarios: the address map and its holes, the active-low summary, the "already paused" answer for a disabled thread, a clearing write racing an event, and a bus write racing a core update.

// File: rtl/cmd_thread_pkg.sv
package cmd_thread_pkg;

  typedef enum logic [3:0] {
    REG_RST, REG_EN, REG_SUSP, REG_STAT, REG_IST,
    REG_IEN, REG_CUR, REG_END, REG_CFG, REG_NONE
  } thrReg_e;

  typedef enum logic [2:0] {
    RD_NONE, RD_GIRQ, RD_LOADED, RD_SLOT, RD_THR
  } rdKind_e;

  typedef struct packed {
    logic wrRst;
    logic wrEn;
    logic wrSusp;
    logic wrIst;
    logic wrIen;
    logic wrCur;
    logic wrEnd;
    logic wrCfg;
  } thrStb_t;

  localparam int CauseW = 5;
  localparam logic [CauseW-1:0] CauseMask = 5'b10011;

  function automatic thrReg_e decodeOff(input logic [7:0] off);
    case (off)
      8'h00:   decodeOff = REG_RST;
      8'h04:   decodeOff = REG_EN;
      8'h08:   decodeOff = REG_SUSP;
      8'h0C:   decodeOff = REG_STAT;
      8'h10:   decodeOff = REG_IST;
      8'h14:   decodeOff = REG_IEN;
      8'h20:   decodeOff = REG_CUR;
      8'h24:   decodeOff = REG_END;
      8'h40:   decodeOff = REG_CFG;
      default: decodeOff = REG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cmd_thread_decode.sv
module cmd_thread_decode
  import cmd_thread_pkg::*;
#(
  parameter int AddrW      = 12,
  parameter int NumThreads = 3,
  parameter int ThrBase    = 256,
  parameter int StrideLog2 = 7,
  parameter int GirqOff    = 16,
  parameter int LoadedOff  = 24,
  parameter int SlotOff    = 48,
  localparam int IdxW      = (NumThreads > 1) ? $clog2(NumThreads) : 1
) (
  input  logic                           regWr,
  input  logic [AddrW-1:0]               regAddr,
  output thrStb_t [NumThreads-1:0]       stbVec,
  output logic                           wrSlot,
  output rdKind_e                        rdKind,
  output logic [IdxW-1:0]                rdThr,
  output thrReg_e                        rdReg
);

  logic [AddrW-1:0] relAddr;
  logic [AddrW-1:0] idxFull;
  logic             inWindow;

  assign relAddr  = regAddr - AddrW'(ThrBase);
  assign idxFull  = relAddr >> StrideLog2;
  assign inWindow = (regAddr >= AddrW'(ThrBase)) && (idxFull < AddrW'(NumThreads));

  always_comb begin
    stbVec = '0;
    wrSlot = 1'b0;
    rdKind = RD_NONE;
    rdThr  = '0;
    rdReg  = REG_NONE;
    if (regAddr[1:0] == 2'b00) begin
      if (regAddr == AddrW'(GirqOff)) begin
        rdKind = RD_GIRQ;
      end else if (regAddr == AddrW'(LoadedOff)) begin
        rdKind = RD_LOADED;
      end else if (regAddr == AddrW'(SlotOff)) begin
        rdKind = RD_SLOT;
        wrSlot = regWr;
      end else if (inWindow) begin
        rdThr = idxFull[IdxW-1:0];
        rdReg = decodeOff(8'(relAddr[StrideLog2-1:0]));
        if (rdReg != REG_NONE) rdKind = RD_THR;
        if (regWr) begin
          case (rdReg)
            REG_RST:  stbVec[rdThr].wrRst  = 1'b1;
            REG_EN:   stbVec[rdThr].wrEn   = 1'b1;
            REG_SUSP: stbVec[rdThr].wrSusp = 1'b1;
            REG_IST:  stbVec[rdThr].wrIst  = 1'b1;
            REG_IEN:  stbVec[rdThr].wrIen  = 1'b1;
            REG_CUR:  stbVec[rdThr].wrCur  = 1'b1;
            REG_END:  stbVec[rdThr].wrEnd  = 1'b1;
            REG_CFG:  stbVec[rdThr].wrCfg  = 1'b1;
            default:  ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/cmd_thread_bank.sv
module cmd_thread_bank
  import cmd_thread_pkg::*;
#(
  parameter int PrioW = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  thrStb_t          stb,
  input  logic [31:0]      wdata,
  input  thrReg_e          rdReg,
  output logic [31:0]      rdWord,
  input  logic             busy,
  input  logic             suspAck,
  input  logic             rstDone,
  input  logic             evtDone,
  input  logic             evtErr,
  input  logic             evtFault,
  input  logic             corePcWe,
  input  logic [31:0]      corePc,
  output logic             startPulse,
  output logic             suspReq,
  output logic             rstReq,
  output logic             pcLoad,
  output logic [31:0]      curAddr,
  output logic [31:0]      endAddr,
  output logic [PrioW-1:0] prio,
  output logic             irqLine
);

  logic              rstPend, enBit, suspBit, suspSeen, startQ, pcLoadQ;
  logic [CauseW-1:0] ist, ien, evt, istKeep;
  logic              rstComplete, suspStat;

  assign rstComplete = rstPend && rstDone;
  assign evt         = {evtFault, 2'b00, evtErr, evtDone};
  assign suspReq     = suspBit && enBit;
  assign suspStat    = suspBit && (!enBit || suspSeen);

  always_comb begin
    istKeep = stb.wrIst ? (ist & wdata[CauseW-1:0]) : ist;
    if (rstComplete) istKeep = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstPend  <= 1'b0;
      enBit    <= 1'b0;
      suspBit  <= 1'b0;
      suspSeen <= 1'b0;
      startQ   <= 1'b0;
      pcLoadQ  <= 1'b0;
      ist      <= '0;
      ien      <= '0;
      curAddr  <= '0;
      endAddr  <= '0;
      prio     <= '0;
    end else begin
      startQ  <= stb.wrEn && wdata[0] && !enBit && !rstComplete;
      pcLoadQ <= stb.wrCur;

      if (stb.wrRst && wdata[0]) rstPend <= 1'b1;
      else if (rstComplete)      rstPend <= 1'b0;

      if (rstComplete)     enBit <= 1'b0;
      else if (stb.wrEn)   enBit <= wdata[0];

      if (stb.wrSusp) suspBit <= wdata[0];

      if (stb.wrSusp && !wdata[0])  suspSeen <= 1'b0;
      else if (suspReq && suspAck)  suspSeen <= 1'b1;

      ist <= (istKeep | evt) & CauseMask;

      if (stb.wrIen) ien <= wdata[CauseW-1:0] & CauseMask;

      if (stb.wrCur)      curAddr <= wdata;
      else if (corePcWe)  curAddr <= corePc;

      if (stb.wrEnd) endAddr <= wdata;
      if (stb.wrCfg) prio    <= wdata[PrioW-1:0];
    end
  end

  assign startPulse = startQ;
  assign pcLoad     = pcLoadQ;
  assign rstReq     = rstPend;
  assign irqLine    = |(ist & ien);

  always_comb begin
    case (rdReg)
      REG_RST:  rdWord = {31'd0, rstPend};
      REG_EN:   rdWord = {31'd0, enBit};
      REG_SUSP: rdWord = {31'd0, suspBit};
      REG_STAT: rdWord = {30'd0, suspStat, busy};
      REG_IST:  rdWord = {{(32-CauseW){1'b0}}, ist};
      REG_IEN:  rdWord = {{(32-CauseW){1'b0}}, ien};
      REG_CUR:  rdWord = curAddr;
      REG_END:  rdWord = endAddr;
      REG_CFG:  rdWord = {{(32-PrioW){1'b0}}, prio};
      default:  rdWord = '0;
    endcase
  end

  // R3: the request holds until the core reports completion
  a_r3_rst_hold: assert property (@(posedge clk) disable iff (!rstN)
    rstPend && !rstDone |=> rstPend);

  // R3: completion drops the request and the enable bit
  a_r3_rst_clear: assert property (@(posedge clk) disable iff (!rstN)
    rstComplete && !(stb.wrRst && wdata[0]) |=> !rstPend && !enBit);

  // R4: an enabled thread only shows paused after an acknowledge
  a_r4_susp_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspStat) && enBit |-> $past(suspAck));

  // R5: a start pulse comes with the enable bit set
  a_r5_start_en: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> enBit);

  // R6: causes written as 0 stay cleared unless an event re-set them
  a_r6_write_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrIst && !rstComplete |=> (ist & ~$past(wdata[CauseW-1:0]) & ~$past(evt)) == '0);

  // R10: every current-address write is followed by a refetch pulse
  a_r10_pc_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCur |=> pcLoad);

endmodule

// File: rtl/cmd_thread_regs.sv
module cmd_thread_regs
  import cmd_thread_pkg::*;
#(
  parameter int AddrW      = 12,
  parameter int NumThreads = 3,
  parameter int PrioW      = 3,
  localparam int IdxW      = (NumThreads > 1) ? $clog2(NumThreads) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWr,
  input  logic [AddrW-1:0]             regAddr,
  input  logic [31:0]                  regWdata,
  output logic [31:0]                  regRdata,
  output logic [NumThreads-1:0]        thrStart,
  output logic [NumThreads-1:0]        thrSuspReq,
  input  logic [NumThreads-1:0]        thrSuspAck,
  output logic [NumThreads-1:0]        thrRstReq,
  input  logic [NumThreads-1:0]        thrRstDone,
  output logic [NumThreads-1:0]        thrPcLoad,
  output logic [NumThreads*32-1:0]     thrCurAddr,
  output logic [NumThreads*32-1:0]     thrEndAddr,
  output logic [NumThreads*PrioW-1:0]  thrPrio,
  input  logic [NumThreads-1:0]        corePcWe,
  input  logic [NumThreads*32-1:0]     corePc,
  input  logic [NumThreads-1:0]        coreBusy,
  input  logic [NumThreads-1:0]        evtDone,
  input  logic [NumThreads-1:0]        evtErr,
  input  logic [NumThreads-1:0]        evtFault,
  output logic [NumThreads-1:0]        thrIrq,
  output logic                         irq,
  output logic [31:0]                  slotCycles
);

  thrStb_t [NumThreads-1:0] stbVec;
  logic                     wrSlot;
  rdKind_e                  rdKind;
  logic [IdxW-1:0]          rdThr;
  thrReg_e                  rdReg;
  logic [31:0]              rdWords [NumThreads];
  logic [31:0]              slotReg;

  cmd_thread_decode #(
    .AddrW(AddrW), .NumThreads(NumThreads), .ThrBase(256), .StrideLog2(7),
    .GirqOff(16), .LoadedOff(24), .SlotOff(48)
  ) u_decode (
    .regWr(regWr), .regAddr(regAddr), .stbVec(stbVec), .wrSlot(wrSlot),
    .rdKind(rdKind), .rdThr(rdThr), .rdReg(rdReg)
  );

  for (genvar g = 0; g < NumThreads; g++) begin : g_thr
    cmd_thread_bank #(.PrioW(PrioW)) u_bank (
      .clk(clk), .rstN(rstN), .stb(stbVec[g]), .wdata(regWdata),
      .rdReg(rdReg), .rdWord(rdWords[g]),
      .busy(coreBusy[g]), .suspAck(thrSuspAck[g]), .rstDone(thrRstDone[g]),
      .evtDone(evtDone[g]), .evtErr(evtErr[g]), .evtFault(evtFault[g]),
      .corePcWe(corePcWe[g]), .corePc(corePc[g*32 +: 32]),
      .startPulse(thrStart[g]), .suspReq(thrSuspReq[g]), .rstReq(thrRstReq[g]),
      .pcLoad(thrPcLoad[g]), .curAddr(thrCurAddr[g*32 +: 32]),
      .endAddr(thrEndAddr[g*32 +: 32]), .prio(thrPrio[g*PrioW +: PrioW]),
      .irqLine(thrIrq[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       slotReg <= '0;
    else if (wrSlot) slotReg <= regWdata;
  end

  assign slotCycles = slotReg;
  assign irq        = |thrIrq;

  always_comb begin
    case (rdKind)
      RD_GIRQ:   regRdata = {16'h0000, ~(16'(thrIrq))};
      RD_LOADED: regRdata = {|coreBusy, 31'd0};
      RD_SLOT:   regRdata = slotReg;
      RD_THR:    regRdata = rdWords[rdThr];
      default:   regRdata = '0;
    endcase
  end

endmodule

// File: tb/cmd_thread_regs_bench.sv
module cmd_thread_regs_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [2:0]  thrStart, thrSuspReq, thrRstReq, thrPcLoad, thrIrq;
  logic [2:0]  thrSuspAck = '0, thrRstDone = '0, corePcWe = '0, coreBusy = '0;
  logic [2:0]  evtDone = '0, evtErr = '0, evtFault = '0;
  logic [95:0] thrCurAddr, thrEndAddr;
  logic [95:0] corePc = '0;
  logic [8:0]  thrPrio;
  logic        irq;
  logic [31:0] slotCycles;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  logic [4:0] expIst [3];
  logic [4:0] expIen [3];

  always #4 clk = ~clk;

  cmd_thread_regs u_cmd_thread_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .thrStart(thrStart), .thrSuspReq(thrSuspReq),
    .thrSuspAck(thrSuspAck), .thrRstReq(thrRstReq), .thrRstDone(thrRstDone),
    .thrPcLoad(thrPcLoad), .thrCurAddr(thrCurAddr), .thrEndAddr(thrEndAddr),
    .thrPrio(thrPrio), .corePcWe(corePcWe), .corePc(corePc), .coreBusy(coreBusy),
    .evtDone(evtDone), .evtErr(evtErr), .evtFault(evtFault), .thrIrq(thrIrq),
    .irq(irq), .slotCycles(slotCycles)
  );

  function automatic logic [11:0] winBase(input int t);
    return 12'h100 + 12'(t) * 12'h080;
  endfunction

  function automatic logic [2:0] expThrIrq();
    logic [2:0] r;
    for (int t = 0; t < 3; t++) r[t] = |(expIst[t] & expIen[t]);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic pulseEvt(input int kind, input int t);
    @(negedge clk);
    case (kind)
      0: evtDone[t] = 1'b1;
      1: evtErr[t] = 1'b1;
      default: evtFault[t] = 1'b1;
    endcase
    @(negedge clk);
    evtDone = '0; evtErr = '0; evtFault = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nRun++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(12'h010, d); chk("R1 summary", d, 32'h0000FFFF);
    rd(12'h104, d); chk("R1 enable", d, 0);
    rd(12'h030, d); chk("R1 slot", d, 0);
    chk("R1 irq", {29'd0, thrIrq}, 0);
    chk("R1 strobes", {thrStart, thrSuspReq, thrRstReq, thrPcLoad}, 0);

    // R12 slot cycles
    wr(12'h030, 32'h00003200);
    rd(12'h030, d); chk("R12 readback", d, 32'h3200);
    chk("R12 output", slotCycles, 32'h3200);

    // R5 enable and start pulse
    wr(12'h104, 1);
    chk("R5 start pulse", {31'd0, thrStart[0]}, 1);
    @(negedge clk); chk("R5 pulse one cycle", {31'd0, thrStart[0]}, 0);
    rd(12'h104, d); chk("R5 enable readback", d, 1);
    wr(12'h104, 1);
    chk("R5 no pulse when already on", {31'd0, thrStart[0]}, 0);

    // R4 pause handshake, enabled thread 0
    wr(12'h108, 1);
    chk("R4 request out", {31'd0, thrSuspReq[0]}, 1);
    rd(12'h10C, d); chk("R4 not yet paused", d, 0);
    @(negedge clk); thrSuspAck[0] = 1'b1;
    @(negedge clk); thrSuspAck[0] = 1'b0;
    rd(12'h10C, d); chk("R4 paused after ack", d, 2);
    wr(12'h108, 0);
    rd(12'h10C, d); chk("R4 resume clears", d, 0);
    chk("R4 request drops", {31'd0, thrSuspReq[0]}, 0);
    // R4 disabled thread 1 counts as paused
    wr(12'h188, 1);
    rd(12'h18C, d); chk("R4 disabled already paused", d, 2);
    chk("R4 disabled no request", {31'd0, thrSuspReq[1]}, 0);
    wr(12'h188, 0);

    // R9 executing flag, R5 status bit 0
    @(negedge clk); coreBusy[1] = 1'b1;
    rd(12'h018, d); chk("R9 busy", d, 32'h80000000);
    rd(12'h18C, d); chk("R5 status busy", d, 1);
    @(negedge clk); coreBusy[1] = 1'b0;
    rd(12'h018, d); chk("R9 idle", d, 0);

    // R6 R7 R8 interrupt causes on thread 1
    wr(12'h194, 32'hFFFFFFFF);
    rd(12'h194, d); chk("R7 mask bits", d, 32'h13);
    pulseEvt(2, 1);
    rd(12'h190, d); chk("R6 fault bit4", d, 32'h10);
    chk("R7 irq", {31'd0, irq}, 1);
    chk("R7 thread line", {29'd0, thrIrq}, 32'h2);
    rd(12'h010, d); chk("R8 active low", d, 32'h0000FFFD);
    wr(12'h190, ~32'h10);
    rd(12'h190, d); chk("R6 clear by zero", d, 0);
    chk("R7 irq low", {31'd0, irq}, 0);
    pulseEvt(1, 1);
    wr(12'h190, 32'hFFFFFFFF);
    rd(12'h190, d); chk("R6 ones keep", d, 2);
    wr(12'h190, ~32'h2);
    rd(12'h190, d); chk("R6 error cleared", d, 0);
    @(negedge clk);
    regAddr = 12'h190; regWdata = 0; regWr = 1'b1; evtDone[1] = 1'b1;
    @(negedge clk);
    regWr = 1'b0; evtDone[1] = 1'b0;
    rd(12'h190, d); chk("R6 event wins over clear", d, 1);
    wr(12'h190, 0);
    wr(12'h194, 0);

    // R3 warm reset on thread 2
    wr(12'h204, 1);
    pulseEvt(0, 2);
    rd(12'h210, d); chk("R3 cause before reset", d, 1);
    wr(12'h200, 1);
    chk("R3 request out", {31'd0, thrRstReq[2]}, 1);
    repeat (3) @(negedge clk);
    rd(12'h200, d); chk("R3 reads 1 while pending", d, 1);
    @(negedge clk); thrRstDone[2] = 1'b1;
    @(negedge clk); thrRstDone[2] = 1'b0;
    rd(12'h200, d); chk("R3 self clears", d, 0);
    rd(12'h204, d); chk("R3 enable cleared", d, 0);
    rd(12'h210, d); chk("R3 causes cleared", d, 0);
    chk("R3 request drops", {31'd0, thrRstReq[2]}, 0);

    // R10 current address and refetch
    wr(12'h120, 32'hABCD0000);
    chk("R10 pcLoad", {31'd0, thrPcLoad[0]}, 1);
    chk("R10 value out", thrCurAddr[31:0], 32'hABCD0000);
    wr(12'h120, 32'hABCD0000);
    chk("R10 pcLoad same value", {31'd0, thrPcLoad[0]}, 1);
    @(negedge clk); corePcWe[0] = 1'b1; corePc[31:0] = 32'h00001234;
    @(negedge clk); corePcWe[0] = 1'b0;
    chk("R10 core update no pulse", {31'd0, thrPcLoad[0]}, 0);
    rd(12'h120, d); chk("R10 core update", d, 32'h1234);
    @(negedge clk);
    regAddr = 12'h120; regWdata = 32'h5555AAAA; regWr = 1'b1;
    corePcWe[0] = 1'b1; corePc[31:0] = 32'h0BAD0000;
    @(negedge clk); regWr = 1'b0; corePcWe[0] = 1'b0;
    rd(12'h120, d); chk("R10 bus wins", d, 32'h5555AAAA);

    // R11 end address and priority
    wr(12'h124, 32'hDEADBEEF);
    rd(12'h124, d); chk("R11 end", d, 32'hDEADBEEF);
    wr(12'h140, 32'hFFFFFFFF);
    rd(12'h140, d); chk("R11 prio masked", d, 7);
    chk("R11 prio out", {29'd0, thrPrio[2:0]}, 7);

    // R2 holes
    rd(12'h11C, d); chk("R2 hole offset", d, 0);
    wr(12'h284, 1);
    rd(12'h284, d); chk("R2 fourth window", d, 0);
    rd(12'h104, d); chk("R2 thread0 untouched", d, 1);
    rd(12'h106, d); chk("R2 unaligned", d, 0);
    rd(12'h0FC, d); chk("R2 below windows", d, 0);
    rd(12'h304, d); chk("R2 window 3 enable", d, 0);

    // random section, R6 R7 R8 R10 R11
    for (int t = 0; t < 3; t++) begin
      wr(winBase(t) + 12'h10, 0);
      wr(winBase(t) + 12'h14, 0);
      expIst[t] = '0; expIen[t] = '0;
    end
    for (int i = 0; i < 400; i++) begin
      int t;
      int op;
      logic [31:0] v;
      t = $urandom_range(0, 2);
      op = $urandom_range(0, 5);
      v = $urandom;
      case (op)
        0: begin
          wr(winBase(t) + 12'h14, v); expIen[t] = v[4:0] & 5'h13;
          rd(winBase(t) + 12'h14, d); chk("R7 rand mask", d, {27'd0, expIen[t]});
        end
        1: begin
          wr(winBase(t) + 12'h10, v); expIst[t] = expIst[t] & v[4:0];
          rd(winBase(t) + 12'h10, d); chk("R6 rand clear", d, {27'd0, expIst[t]});
        end
        2: begin
          int k;
          k = $urandom_range(0, 2);
          pulseEvt(k, t);
          expIst[t] = expIst[t] | ((k == 0) ? 5'h01 : (k == 1) ? 5'h02 : 5'h10);
          rd(winBase(t) + 12'h10, d); chk("R6 rand event", d, {27'd0, expIst[t]});
        end
        3: begin
          wr(winBase(t) + 12'h20, v);
          chk("R10 rand pulse", {31'd0, thrPcLoad[t]}, 1);
          rd(winBase(t) + 12'h20, d); chk("R10 rand value", d, v);
        end
        4: begin
          wr(winBase(t) + 12'h24, v);
          rd(winBase(t) + 12'h24, d); chk("R11 rand end", d, v);
        end
        default: begin
          wr(winBase(t) + 12'h40, v);
          rd(winBase(t) + 12'h40, d); chk("R11 rand prio", d, {29'd0, v[2:0]});
        end
      endcase
      chk("R7 rand lines", {29'd0, thrIrq}, {29'd0, expThrIrq()});
      chk("R7 rand irq", {31'd0, irq}, {31'd0, |expThrIrq()});
      rd(12'h010, d); chk("R8 rand summary", d, {16'h0000, 13'h1FFF, ~expThrIrq()});
    end

    summary();
  end

endmodule